// File: doc/BRIEF.md
# LIN Slave Break Detector and Baud Synchroniser

This block sits on the receive line of a LIN slave node. It watches the incoming serial line and recognises a long low period as a break. The low period must be at least a fixed number of bit times long, measured with the bit divisor that is currently in force. After a valid break the block times the sync byte that follows. That byte is 0x55, so it has falling edges at the start bit and at data bits 1, 3, 5 and 7.

A free-running clock-cycle timer is captured on the first falling edge. It is compared again on the fifth falling edge. The interval between the two edges spans eight bit periods, so the interval shifted right by three is the master's bit period in clock cycles. When that value lies inside the allowed window, it becomes the new divisor for the receive bit-timing logic and a done pulse is issued. When it lies outside the window, or when the fifth edge is late, an error pulse is issued and the old divisor stays in force.

The divisor output is meant to feed the receiver's bit-sampling counter directly. The break and done pulses let the frame logic arm itself for the identifier byte.

Top module: `lin_baud_sync`

## Requirements
- R1: While reset is asserted, `break_o`, `sync_done_o` and `sync_err_o` are low and `baud_div_o` equals the parameter `DIV_INIT` (16 by default).
- R2: A break is recognised, and `break_o` pulses for one cycle, only when the synchronised line has been low for at least `BREAK_BITS` (13) times `baud_div_o` clock cycles before it returns high. A low period one cycle shorter gives no pulse and starts no synchronisation.
- R3: After a recognised break, the clock count between the first and fifth falling edges of the sync byte is shifted right by 3. That result is loaded into `baud_div_o` in the same cycle in which `sync_done_o` pulses high for one cycle.
- R4: Falling edges, short glitches and whole 0x55 bytes that arrive without a preceding recognised break produce no pulse and leave `baud_div_o` unchanged.
- R5: If the fifth falling edge has not been seen before `TIMEOUT_BITS` (16) times `baud_div_o` clock cycles have elapsed since the first, `sync_err_o` pulses and `baud_div_o` is unchanged. An edge arriving exactly at the limit counts as late. The block then waits for a new break.
- R6: A measured divisor below `DIV_MIN` (8) or above `DIV_MAX` (24) is rejected: `sync_err_o` pulses and `baud_div_o` is unchanged. The values 8 and 24 themselves are accepted.
- R7: The break length threshold always uses the divisor loaded most recently, so it tracks every successful synchronisation.
- R8: `sync_done_o` and `sync_err_o` are never high together, and each is high for a single cycle per event.
- R9: `rx_i` passes through two flip-flops before edge detection. `break_o` is high in the cycle that follows the third rising clock edge at which `rx_i` is sampled high after a valid break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| break_o | output | 1 | One-cycle pulse when a valid break ends |
| sync_done_o | output | 1 | One-cycle pulse when a new divisor has been loaded |
| sync_err_o | output | 1 | One-cycle pulse when synchronisation failed |
| baud_div_o | output | DIV_W | Bit period in clock cycles used by the receiver |

## Verification
Sync bytes are sent at bit periods of 6, 8, 12, 16, 20, 23, 24 and 25 clocks. These separate a correct load from the two limit rejections, and separate an exact in-range load from a timeout that lands on the same cycle as the fifth edge. Break lengths are driven exactly at and one below the threshold, under several loaded divisors. This distinguishes a threshold that uses the live divisor from one fixed at reset. A byte of 0xFF after a break gives a single falling edge and exercises the timeout. Glitches and sync bytes sent with no break show that stray edges cannot start a measurement.

// File: rtl/lin_sync_pkg.sv
package lin_sync_pkg;

  typedef enum logic [1:0] {
    SY_IDLE = 2'd0,
    SY_ARM  = 2'd1,
    SY_MEAS = 2'd2
  } sync_state_e;

endpackage

// File: rtl/lin_rx_edge.sv
module lin_rx_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic lvl_o,
  output logic fall_o,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;

  // Metastability chain, idle-high reset.
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = rx_i;
      end else begin : g_next
        assign chain_d[g] = chain_q[g-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b1;
        else        chain_q[g] <= chain_d[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign fall_o = last_q & ~chain_q[STAGES-1];
  assign rise_o = ~last_q & chain_q[STAGES-1];

endmodule

// File: rtl/lin_break_det.sv
module lin_break_det #(
  parameter int DIV_W      = 16,
  parameter int BREAK_BITS = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_i,
  input  logic             rise_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             brk_o
);

  localparam int MUL_W = $clog2(BREAK_BITS + 1);
  localparam int CNT_W = DIV_W + MUL_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] low_q, low_d;
  logic [CNT_W-1:0] thresh;
  logic             low_en;
  logic             brk_q, brk_d;

  // Threshold follows the live divisor.
  assign thresh = CNT_W'(div_i) * CNT_W'(BREAK_BITS);

  always_comb begin
    low_en = 1'b0;
    low_d  = low_q;
    if (lvl_i) begin
      low_en = (low_q != '0);
      low_d  = '0;
    end else if (low_q != CNT_MAX) begin
      low_en = 1'b1;
      low_d  = low_q + 1'b1;
    end
    brk_d = rise_i && (low_q >= thresh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_q <= '0;
    else if (low_en) low_q <= low_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_q <= 1'b0;
    else        brk_q <= brk_d;
  end

  assign brk_o = brk_q;

endmodule

// File: rtl/lin_sync_meas.sv
module lin_sync_meas
  import lin_sync_pkg::*;
#(
  parameter int DIV_W        = 16,
  parameter int TMR_W        = 24,
  parameter int TIMEOUT_BITS = 16,
  parameter int DIV_MIN      = 8,
  parameter int DIV_MAX      = 24,
  parameter int DIV_INIT     = 16,
  parameter int SYNC_FALLS   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             brk_i,
  input  logic             fall_i,
  output logic [DIV_W-1:0] div_o,
  output logic             done_o,
  output logic             err_o
);

  // Edges of 0x55 are two bits apart; span between first and last.
  localparam int SPAN_BITS  = 2 * (SYNC_FALLS - 1);
  localparam int SPAN_SHIFT = $clog2(SPAN_BITS);
  localparam int EC_W       = $clog2(SYNC_FALLS);
  localparam logic [EC_W-1:0] LAST_IDX = EC_W'(SYNC_FALLS - 2);

  sync_state_e      st_q, st_d;
  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W-1:0] cap_q, cap_d;
  logic             cap_en;
  logic [EC_W-1:0]  ec_q, ec_d;
  logic             ec_en;
  logic [DIV_W-1:0] div_q, div_d;
  logic             div_en;
  logic             done_q, done_d;
  logic             err_q, err_d;

  logic [TMR_W-1:0] elapsed;
  logic [TMR_W-1:0] tmo_lim;
  logic [TMR_W-1:0] cand;
  logic             late;
  logic             in_win;

  assign elapsed = tmr_q - cap_q;
  assign tmo_lim = TMR_W'(div_q) * TMR_W'(TIMEOUT_BITS);
  assign late    = (elapsed >= tmo_lim);
  assign cand    = elapsed >> SPAN_SHIFT;
  assign in_win  = (cand >= TMR_W'(DIV_MIN)) && (cand <= TMR_W'(DIV_MAX));

  always_comb begin
    st_d   = st_q;
    cap_d  = cap_q;
    cap_en = 1'b0;
    ec_d   = ec_q;
    ec_en  = 1'b0;
    div_d  = div_q;
    div_en = 1'b0;
    done_d = 1'b0;
    err_d  = 1'b0;
    unique case (st_q)
      SY_IDLE: begin
        if (brk_i) st_d = SY_ARM;
      end
      SY_ARM: begin
        if (fall_i) begin
          st_d   = SY_MEAS;
          cap_d  = tmr_q;
          cap_en = 1'b1;
          ec_d   = '0;
          ec_en  = 1'b1;
        end
      end
      SY_MEAS: begin
        if (late) begin
          st_d  = SY_IDLE;
          err_d = 1'b1;
        end else if (fall_i) begin
          if (ec_q == LAST_IDX) begin
            st_d = SY_IDLE;
            if (in_win) begin
              div_d  = cand[DIV_W-1:0];
              div_en = 1'b1;
              done_d = 1'b1;
            end else begin
              err_d = 1'b1;
            end
          end else begin
            ec_d  = ec_q + 1'b1;
            ec_en = 1'b1;
          end
        end
      end
      default: st_d = SY_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SY_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= cap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ec_q <= '0;
    else if (ec_en) ec_q <= ec_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= DIV_W'(DIV_INIT);
    else if (div_en) div_q <= div_d;
  end

  assign div_o  = div_q;
  assign done_o = done_q;
  assign err_o  = err_q;

endmodule

// File: rtl/lin_baud_sync.sv
module lin_baud_sync #(
  parameter int DIV_W        = 16,
  parameter int TMR_W        = 24,
  parameter int SYNC_STAGES  = 2,
  parameter int BREAK_BITS   = 13,
  parameter int TIMEOUT_BITS = 16,
  parameter int DIV_MIN      = 8,
  parameter int DIV_MAX      = 24,
  parameter int DIV_INIT     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  output logic             break_o,
  output logic             sync_done_o,
  output logic             sync_err_o,
  output logic [DIV_W-1:0] baud_div_o
);

  logic             rx_lvl;
  logic             rx_fall;
  logic             rx_rise;
  logic             brk;
  logic [DIV_W-1:0] div;

  lin_rx_edge #(
    .STAGES (SYNC_STAGES)
  ) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (rx_i),
    .lvl_o  (rx_lvl),
    .fall_o (rx_fall),
    .rise_o (rx_rise)
  );

  lin_break_det #(
    .DIV_W      (DIV_W),
    .BREAK_BITS (BREAK_BITS)
  ) u_brk (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (rx_lvl),
    .rise_i (rx_rise),
    .div_i  (div),
    .brk_o  (brk)
  );

  lin_sync_meas #(
    .DIV_W        (DIV_W),
    .TMR_W        (TMR_W),
    .TIMEOUT_BITS (TIMEOUT_BITS),
    .DIV_MIN      (DIV_MIN),
    .DIV_MAX      (DIV_MAX),
    .DIV_INIT     (DIV_INIT),
    .SYNC_FALLS   (5)
  ) u_meas (
    .clk    (clk),
    .rst_n  (rst_n),
    .brk_i  (brk),
    .fall_i (rx_fall),
    .div_o  (div),
    .done_o (sync_done_o),
    .err_o  (sync_err_o)
  );

  assign break_o    = brk;
  assign baud_div_o = div;

endmodule

// File: rtl/lin_baud_sync_chk.sv
module lin_baud_sync_chk #(
  parameter int DIV_W   = 16,
  parameter int DIV_MIN = 8,
  parameter int DIV_MAX = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             brk,
  input logic             done,
  input logic             err,
  input logic [DIV_W-1:0] div
);

  p_brk_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !brk);

  p_div_moves_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div) |-> done);

  p_done_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (div >= DIV_W'(DIV_MIN)) && (div <= DIV_W'(DIV_MAX)));

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

endmodule

bind lin_baud_sync lin_baud_sync_chk #(
  .DIV_W   (DIV_W),
  .DIV_MIN (DIV_MIN),
  .DIV_MAX (DIV_MAX)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .brk   (break_o),
  .done  (sync_done_o),
  .err   (sync_err_o),
  .div   (baud_div_o)
);

// File: tb/tb_lin_baud_sync.sv
`timescale 1ns/1ps
module tb_lin_baud_sync;

  localparam int DIV_W = 16;
  localparam int K_BRK = 0;
  localparam int K_DONE = 1;
  localparam int K_ERR = 2;

  logic             clk;
  logic             rst_n;
  logic             rx;
  logic             break_o;
  logic             sync_done_o;
  logic             sync_err_o;
  logic [DIV_W-1:0] baud_div_o;

  int    vecs;
  int    miss;
  bit    finished;
  int    cur;
  int    exp_kind[$];
  int    exp_div[$];
  string exp_req[$];

  lin_baud_sync dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_i        (rx),
    .break_o     (break_o),
    .sync_done_o (sync_done_o),
    .sync_err_o  (sync_err_o),
    .baud_div_o  (baud_div_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int k, input int d, input string r);
    exp_kind.push_back(k);
    exp_div.push_back(d);
    exp_req.push_back(r);
  endtask

  // Scoreboard side: compare each event against the queue head.
  task automatic take(input int k);
    int    ek;
    int    ed;
    string er;
    if (exp_kind.size() == 0) begin
      check(1'b0, "R4", "unexpected event kind", k, -1);
    end else begin
      ek = exp_kind.pop_front();
      ed = exp_div.pop_front();
      er = exp_req.pop_front();
      check(ek == k, er, "event kind", k, ek);
      if (k != K_BRK)
        check(int'(baud_div_o) == ed, er, "divisor after event", int'(baud_div_o), ed);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (break_o)     take(K_BRK);
      if (sync_done_o) take(K_DONE);
      if (sync_err_o)  take(K_ERR);
    end
  end

  task automatic hold(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int bc);
    hold(1'b0, bc);
    for (int i = 0; i < 8; i++) hold(b[i], bc);
    hold(1'b1, bc);
  endtask

  task automatic frame(input int brk_len, input int bc, input logic [7:0] b);
    hold(1'b0, brk_len);
    hold(1'b1, 32);
    send_byte(b, bc);
    hold(1'b1, 256);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miss++;
      $display("FAIL R3 watchdog: got %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    vecs = 0;
    miss = 0;
    finished = 1'b0;
    cur = 16;
    rst_n = 1'b0;
    rx = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(break_o == 1'b0, "R1", "break_o in reset", int'(break_o), 0);
    check(sync_done_o == 1'b0, "R1", "done in reset", int'(sync_done_o), 0);
    check(sync_err_o == 1'b0, "R1", "err in reset", int'(sync_err_o), 0);
    check(int'(baud_div_o) == 16, "R1", "divisor in reset", int'(baud_div_o), 16);
    rst_n = 1'b1;
    hold(1'b1, 20);

    // R4: glitch and sync byte with no break
    hold(1'b0, 3);
    hold(1'b1, 40);
    send_byte(8'h55, 16);
    hold(1'b1, 256);

    // R9 and R2 exact threshold, R3 load at 16
    push(K_BRK, 0, "R2");
    push(K_DONE, 16, "R3");
    hold(1'b0, 13 * cur);
    rx = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(break_o == 1'b0, "R9", "break_o two edges after release", int'(break_o), 0);
    @(negedge clk);
    check(break_o == 1'b1, "R9", "break_o three edges after release", int'(break_o), 1);
    hold(1'b1, 29);
    send_byte(8'h55, 16);
    hold(1'b1, 256);

    // R2 one cycle short
    frame(13 * cur - 1, 16, 8'h55);

    // R3 load 20
    push(K_BRK, 0, "R2");
    push(K_DONE, 20, "R3");
    frame(13 * cur, 20, 8'h55);
    cur = 20;

    // R6 above maximum
    push(K_BRK, 0, "R7");
    push(K_ERR, cur, "R6");
    frame(13 * cur, 25, 8'h55);

    // R7: 259 exceeds the reset-time threshold but not the live one
    frame(13 * cur - 1, 20, 8'h55);

    // R3 load 12
    push(K_BRK, 0, "R7");
    push(K_DONE, 12, "R3");
    frame(13 * cur, 12, 8'h55);
    cur = 12;

    // R6 below minimum
    push(K_BRK, 0, "R7");
    push(K_ERR, cur, "R6");
    frame(13 * cur, 6, 8'h55);

    // R5 single falling edge
    push(K_BRK, 0, "R2");
    push(K_ERR, cur, "R5");
    frame(13 * cur, 12, 8'hFF);

    // R5 fifth edge exactly at the limit
    push(K_BRK, 0, "R2");
    push(K_ERR, cur, "R5");
    frame(13 * cur, 24, 8'h55);

    // R3 just inside the limit
    push(K_BRK, 0, "R2");
    push(K_DONE, 23, "R3");
    frame(13 * cur, 23, 8'h55);
    cur = 23;

    // R6 maximum accepted
    push(K_BRK, 0, "R7");
    push(K_DONE, 24, "R6");
    frame(13 * cur, 24, 8'h55);
    cur = 24;

    // R6 minimum accepted
    push(K_BRK, 0, "R7");
    push(K_DONE, 8, "R6");
    frame(13 * cur, 8, 8'h55);
    cur = 8;

    // R7 short break accepted at the new divisor
    push(K_BRK, 0, "R7");
    push(K_DONE, 9, "R3");
    frame(13 * cur, 9, 8'h55);
    cur = 9;

    hold(1'b1, 100);
    check(exp_kind.size() == 0, "R3", "pending expected events",
          exp_kind.size(), 0);
    check(int'(baud_div_o) == cur, "R3", "final divisor", int'(baud_div_o), cur);

    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

endmodule